// File: doc/BRIEF.md
# TMDS Video Period Detector

This block watches three word-aligned channels of 10-bit TMDS symbols from an HDMI receiver, one symbol per channel on each pixel clock. It classifies every clock as control, guard band or active pixel. A video period counts only when a run of exactly `PRE_LEN` video-preamble cycles on channels 1 and 2 is followed by `GUARD_LEN` guard-band words. Guard words are legal pixel-data symbols, so the block finds them by their position after the preamble and not by their value. It removes them from the pixel stream and checks them against the expected guard pattern.

The outputs give the frame structure: a video-active flag that covers the guard band and the pixels, a data-enable for pixels only, horizontal and vertical sync taken from the channel 0 control code, a strobe on each guard word, and an error pulse when a guard word is wrong. The symbols of pixel cycles are passed on raw, so TMDS 8b/10b decoding can sit after this block. Every output is registered one clock after the symbols it describes.

Top module: `tmds_vid_framer`

## Requirements
- R1: Control symbols decode to the bit pair {C1,C0} as 10'h354→00, 10'h0AB→01, 10'h154→10, 10'h2AB→11. On every clock in which channel 0 carries a control symbol, hsync_o takes its C0 and vsync_o takes its C1. Otherwise both hold their value.
- R2: A video preamble clock is one in which all three channels carry control symbols, channel 1 carries 01 and channel 2 carries 00. The first clock with no control symbol on any channel, following exactly PRE_LEN (default 8) consecutive preamble clocks, is the first guard word.
- R3: A preamble run shorter or longer than PRE_LEN, or broken by any other clock, starts no video period. Non-control symbols that follow it give de_o=0 and vid_active_o=0.
- R4: A data-island preamble (channel 1 and channel 2 both 01) never starts a video period, whatever its length.
- R5: The GUARD_LEN (default 2) clocks after the preamble are guard words. Each gives guard_o=1, vid_active_o=1 and de_o=0, and is never presented on the pixel outputs.
- R6: A guard word is expected to be 10'h2CC on channels 0 and 2 and 10'h133 on channel 1. Any mismatch pulses guard_err_o for that clock and does not change the classification.
- R7: A control symbol on any channel during the guard band after its first word ends the period: guard_err_o=1, vid_active_o=0 and guard_o=0 for that clock.
- R8: After the guard band, every clock with no control symbol on any channel is pixel data: de_o=1, vid_active_o=1, and pix0_o..pix2_o equal the input symbols.
- R9: The first clock in which any channel carries a control symbol ends the video period (vid_active_o=0, de_o=0). That clock also counts toward a new preamble run.
- R10: All outputs reflect the symbols of the previous clock. During reset every output is 0.
- R11: pix0_o, pix1_o and pix2_o are zero whenever de_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym0_i | input | 10 | Channel 0 TMDS symbol |
| sym1_i | input | 10 | Channel 1 TMDS symbol |
| sym2_i | input | 10 | Channel 2 TMDS symbol |
| vid_active_o | output | 1 | Guard band or pixel clock |
| de_o | output | 1 | Pixel data enable |
| hsync_o | output | 1 | Recovered horizontal sync |
| vsync_o | output | 1 | Recovered vertical sync |
| guard_o | output | 1 | Guard word strobe |
| guard_err_o | output | 1 | Guard word mismatch or aborted guard band |
| pix0_o | output | 10 | Channel 0 pixel symbol, zero outside de_o |
| pix1_o | output | 10 | Channel 1 pixel symbol, zero outside de_o |
| pix2_o | output | 10 | Channel 2 pixel symbol, zero outside de_o |

## Verification
The preamble length is swept from 0 to 11 clocks ahead of an otherwise valid guard band and pixel burst. Only length 8 may open a period, which separates an exact-length match from "at least" matching and from counter overflow. Bursts whose pixel values equal the guard symbols show that position, not value, drives the classification. Data-island preambles, a preamble broken in the middle, and corrupted or interrupted guard bands cover rejection and the error pulse. Every sync code on channel 0, and a control symbol on each channel in turn during pixels, confirm the sync recovery and that the period ends on any channel.

// File: rtl/tvf_pkg.sv
package tvf_pkg;

  localparam int SYM_W = 10;
  localparam int NCH   = 3;

  localparam logic [SYM_W-1:0] CTL_00 = 10'h354;
  localparam logic [SYM_W-1:0] CTL_01 = 10'h0AB;
  localparam logic [SYM_W-1:0] CTL_10 = 10'h154;
  localparam logic [SYM_W-1:0] CTL_11 = 10'h2AB;

  localparam logic [SYM_W-1:0] GB_OUTER = 10'h2CC;
  localparam logic [SYM_W-1:0] GB_MID   = 10'h133;

  localparam logic [1:0] PRE_CH1 = 2'b01;
  localparam logic [1:0] PRE_CH2 = 2'b00;

  typedef struct packed {
    logic       hit;
    logic [1:0] code;
  } ctl_t;

  typedef enum logic [1:0] {
    PH_CTRL   = 2'd0,
    PH_GUARD  = 2'd1,
    PH_ACTIVE = 2'd2
  } phase_e;

  function automatic ctl_t ctl_decode(input logic [SYM_W-1:0] s);
    ctl_t r;
    r.hit  = 1'b1;
    r.code = 2'b00;
    unique case (s)
      CTL_00:  r.code = 2'b00;
      CTL_01:  r.code = 2'b01;
      CTL_10:  r.code = 2'b10;
      CTL_11:  r.code = 2'b11;
      default: r.hit  = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [SYM_W-1:0] guard_word(input int ch);
    return (ch == 1) ? GB_MID : GB_OUTER;
  endfunction

  function automatic logic is_video_pre(input logic [NCH-1:0] hits,
                                        input logic [1:0] code1,
                                        input logic [1:0] code2);
    return (&hits) && (code1 == PRE_CH1) && (code2 == PRE_CH2);
  endfunction

endpackage

// File: rtl/tvf_ctl_decode.sv
module tvf_ctl_decode
  import tvf_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic [SYM_W-1:0] sym,
  output logic             ctl_hit,
  output logic [1:0]       ctl_code,
  output logic             guard_hit
);
  ctl_t dec;

  always_comb begin
    dec       = ctl_decode(sym);
    ctl_hit   = dec.hit;
    ctl_code  = dec.code;
    guard_hit = (sym == guard_word(CH));
  end
endmodule

// File: rtl/tvf_preamble_run.sv
module tvf_preamble_run #(
  parameter int PRE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pre_hit,
  output logic run_full
);
  localparam int CNT_MAX = PRE_LEN + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!pre_hit) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_W'(CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run_full = (cnt_q == CNT_W'(PRE_LEN));
endmodule

// File: rtl/tvf_phase_fsm.sv
module tvf_phase_fsm
  import tvf_pkg::*;
#(
  parameter int GUARD_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_ctl,
  input  logic run_full,
  input  logic guard_match,
  output logic cls_guard,
  output logic cls_pixel,
  output logic guard_fault
);
  localparam int GCNT_W = $clog2(GUARD_LEN + 1);
  localparam logic [GCNT_W-1:0] G_LAST = GCNT_W'(GUARD_LEN - 1);

  phase_e           ph_q, ph_d;
  logic [GCNT_W-1:0] gcnt_q, gcnt_d;

  always_comb begin
    ph_d        = ph_q;
    gcnt_d      = gcnt_q;
    cls_guard   = 1'b0;
    cls_pixel   = 1'b0;
    guard_fault = 1'b0;
    unique case (ph_q)
      PH_CTRL: begin
        if (!any_ctl && run_full) begin
          cls_guard   = 1'b1;
          guard_fault = !guard_match;
          if (GUARD_LEN == 1) begin
            ph_d = PH_ACTIVE;
          end else begin
            ph_d   = PH_GUARD;
            gcnt_d = GCNT_W'(1);
          end
        end
      end
      PH_GUARD: begin
        if (any_ctl) begin
          guard_fault = 1'b1;
          ph_d        = PH_CTRL;
        end else begin
          cls_guard   = 1'b1;
          guard_fault = !guard_match;
          gcnt_d      = gcnt_q + 1'b1;
          if (gcnt_q == G_LAST) ph_d = PH_ACTIVE;
        end
      end
      PH_ACTIVE: begin
        if (any_ctl) ph_d = PH_CTRL;
        else         cls_pixel = 1'b1;
      end
      default: ph_d = PH_CTRL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_CTRL;
      gcnt_q <= '0;
    end else begin
      ph_q   <= ph_d;
      gcnt_q <= gcnt_d;
    end
  end
endmodule

// File: rtl/tmds_vid_framer.sv
module tmds_vid_framer
  import tvf_pkg::*;
#(
  parameter int PRE_LEN   = 8,
  parameter int GUARD_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym0_i,
  input  logic [SYM_W-1:0] sym1_i,
  input  logic [SYM_W-1:0] sym2_i,
  output logic             vid_active_o,
  output logic             de_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             guard_o,
  output logic             guard_err_o,
  output logic [SYM_W-1:0] pix0_o,
  output logic [SYM_W-1:0] pix1_o,
  output logic [SYM_W-1:0] pix2_o
);
  logic [SYM_W-1:0] sym_a [NCH];
  logic [NCH-1:0]   hit_v;
  logic [NCH-1:0]   gm_v;
  logic [1:0]       code_a [NCH];

  assign sym_a[0] = sym0_i;
  assign sym_a[1] = sym1_i;
  assign sym_a[2] = sym2_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
    tvf_ctl_decode #(.CH(ch)) u_dec (
      .sym       (sym_a[ch]),
      .ctl_hit   (hit_v[ch]),
      .ctl_code  (code_a[ch]),
      .guard_hit (gm_v[ch])
    );
  end

  // Named internal events, observed by the bound checker
  logic any_ctl_w;
  logic ch0_ctl_w;
  logic pre_hit_w;
  logic run_full_w;
  logic cls_guard_w;
  logic cls_pixel_w;
  logic fault_w;

  assign any_ctl_w = |hit_v;
  assign ch0_ctl_w = hit_v[0];
  assign pre_hit_w = is_video_pre(hit_v, code_a[1], code_a[2]);

  tvf_preamble_run #(.PRE_LEN(PRE_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_hit  (pre_hit_w),
    .run_full (run_full_w)
  );

  tvf_phase_fsm #(.GUARD_LEN(GUARD_LEN)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .any_ctl     (any_ctl_w),
    .run_full    (run_full_w),
    .guard_match (&gm_v),
    .cls_guard   (cls_guard_w),
    .cls_pixel   (cls_pixel_w),
    .guard_fault (fault_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_active_o <= 1'b0;
      de_o         <= 1'b0;
      guard_o      <= 1'b0;
      guard_err_o  <= 1'b0;
      hsync_o      <= 1'b0;
      vsync_o      <= 1'b0;
      pix0_o       <= '0;
      pix1_o       <= '0;
      pix2_o       <= '0;
    end else begin
      vid_active_o <= cls_guard_w | cls_pixel_w;
      de_o         <= cls_pixel_w;
      guard_o      <= cls_guard_w;
      guard_err_o  <= fault_w;
      pix0_o       <= cls_pixel_w ? sym0_i : '0;
      pix1_o       <= cls_pixel_w ? sym1_i : '0;
      pix2_o       <= cls_pixel_w ? sym2_i : '0;
      if (ch0_ctl_w) begin
        hsync_o <= code_a[0][0];
        vsync_o <= code_a[0][1];
      end
    end
  end
endmodule

// File: rtl/tvf_checker.sv
module tvf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       vid_active_o,
  input logic       de_o,
  input logic       guard_o,
  input logic       guard_err_o,
  input logic       hsync_o,
  input logic       vsync_o,
  input logic [9:0] pix0_o,
  input logic [9:0] pix1_o,
  input logic [9:0] pix2_o,
  input logic       any_ctl_w,
  input logic       ch0_ctl_w,
  input logic       run_full_w
);
  assert_de_in_video_R8: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> vid_active_o);

  assert_guard_not_pixel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(guard_o && de_o));

  assert_de_after_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_o) |-> $past(guard_o));

  assert_guard_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(guard_o) |-> $past(run_full_w));

  assert_pix_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !de_o |-> (pix0_o == '0 && pix1_o == '0 && pix2_o == '0));

  assert_end_on_ctl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vid_active_o) |-> $past(any_ctl_w));

  assert_sync_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ch0_ctl_w) |-> $stable({hsync_o, vsync_o}));

  assert_abort_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_err_o && !guard_o) |-> !vid_active_o);
endmodule

bind tmds_vid_framer tvf_checker u_tvf_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .vid_active_o (vid_active_o),
  .de_o         (de_o),
  .guard_o      (guard_o),
  .guard_err_o  (guard_err_o),
  .hsync_o      (hsync_o),
  .vsync_o      (vsync_o),
  .pix0_o       (pix0_o),
  .pix1_o       (pix1_o),
  .pix2_o       (pix2_o),
  .any_ctl_w    (any_ctl_w),
  .ch0_ctl_w    (ch0_ctl_w),
  .run_full_w   (run_full_w)
);

// File: tb/tmds_vid_framer_bench.sv
module tmds_vid_framer_bench;
  localparam int PRE = 8;
  localparam int GL  = 2;
  localparam logic [9:0] C00 = 10'h354, C01 = 10'h0AB, C10 = 10'h154, C11 = 10'h2AB;
  localparam logic [9:0] GO = 10'h2CC, GM = 10'h133;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] s0 = C00, s1 = C00, s2 = C00;
  logic vid, de, hs, vs, gs, ge;
  logic [9:0] p0, p1, p2;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  tmds_vid_framer u_tmds_vid_framer (
    .clk(clk), .rst_n(rst_n), .sym0_i(s0), .sym1_i(s1), .sym2_i(s2),
    .vid_active_o(vid), .de_o(de), .hsync_o(hs), .vsync_o(vs),
    .guard_o(gs), .guard_err_o(ge), .pix0_o(p0), .pix1_o(p1), .pix2_o(p2)
  );

  // Reference state, written from the requirements
  int m_run = 0, m_phase = 0, m_g = 0;
  logic m_hs = 0, m_vs = 0;
  logic e_vid, e_de, e_gs, e_ge;
  logic [9:0] e_p0, e_p1, e_p2;

  function automatic int code_of(input logic [9:0] s);
    if (s == C00) return 0;
    if (s == C01) return 1;
    if (s == C10) return 2;
    if (s == C11) return 3;
    return -1;
  endfunction

  function automatic logic [9:0] ctl_sym(input int c);
    case (c)
      0: return C00;
      1: return C01;
      2: return C10;
      default: return C11;
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model(input logic [9:0] a, input logic [9:0] b, input logic [9:0] c);
    int k0 = code_of(a), k1 = code_of(b), k2 = code_of(c);
    bit anyc = (k0 >= 0) || (k1 >= 0) || (k2 >= 0);
    bit pre  = (k0 >= 0) && (k1 == 1) && (k2 == 0);
    bit gok  = (a == GO) && (b == GM) && (c == GO);
    e_vid = 0; e_de = 0; e_gs = 0; e_ge = 0; e_p0 = 0; e_p1 = 0; e_p2 = 0;
    if (m_phase == 0) begin
      if (!anyc && m_run == PRE) begin
        e_gs = 1; e_vid = 1; e_ge = !gok; m_g = 1;
        m_phase = (GL == 1) ? 2 : 1;
      end
    end else if (m_phase == 1) begin
      if (anyc) begin e_ge = 1; m_phase = 0; end
      else begin
        e_gs = 1; e_vid = 1; e_ge = !gok; m_g++;
        if (m_g == GL) m_phase = 2;
      end
    end else begin
      if (anyc) m_phase = 0;
      else begin e_de = 1; e_vid = 1; e_p0 = a; e_p1 = b; e_p2 = c; end
    end
    m_run = pre ? ((m_run < PRE + 1) ? m_run + 1 : m_run) : 0;
    if (k0 >= 0) begin m_hs = k0[0]; m_vs = k0[1]; end
  endtask

  task automatic cyc(input logic [9:0] a, input logic [9:0] b, input logic [9:0] c,
                     input string tag);
    @(negedge clk);
    s0 = a; s1 = b; s2 = c;
    model(a, b, c);
    @(posedge clk);
    #2;
    chk({tag, " vid R8 R9"}, vid, e_vid);
    chk({tag, " de R8"}, de, e_de);
    chk({tag, " guard R5"}, gs, e_gs);
    chk({tag, " guard_err R6 R7"}, ge, e_ge);
    chk({tag, " sync R1"}, {vs, hs}, {m_vs, m_hs});
    chk({tag, " pix R11"}, {p0, p1, p2}, {e_p0, e_p1, e_p2});
  endtask

  task automatic preamble(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(ctl_sym(i % 4), C01, C00, tag);
  endtask

  task automatic guard_pair(input string tag);
    for (int i = 0; i < GL; i++) cyc(GO, GM, GO, tag);
  endtask

  task automatic pixels(input int n, input int seed, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [9:0] v = 10'((seed + i * 37) * 13 + 5);
      if (code_of(v) >= 0) v = v ^ 10'h001;
      cyc(v, v ^ 10'h155, v ^ 10'h0F0, tag);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(C00, C00, C00, tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    #35;
    chk("reset vid R10", vid, 0);
    chk("reset de R10", de, 0);
    chk("reset guard R10", gs, 0);
    chk("reset err R10", ge, 0);
    chk("reset sync R10", {vs, hs}, 0);
    chk("reset pix R10", {p0, p1, p2}, 0);
    @(negedge clk);
    rst_n = 1;

    // R1: every sync code on channel 0
    for (int c = 0; c < 4; c++) cyc(ctl_sym(c), C00, C00, "sync sweep R1");
    for (int c = 3; c >= 0; c--) cyc(ctl_sym(c), C10, C11, "sync sweep R1");

    // R2 R3: preamble length sweep, only PRE opens a period
    for (int n = 0; n <= PRE + 3; n++) begin
      idle(2, "len sweep R3");
      preamble(n, "len sweep R2");
      guard_pair("len sweep R2 R5");
      pixels(6, n, "len sweep R8");
      idle(1, "len sweep R9");
    end

    // R8: pixel values identical to guard symbols are still pixels
    idle(2, "guard-valued R8");
    preamble(PRE, "guard-valued R2");
    guard_pair("guard-valued R5");
    for (int i = 0; i < 4; i++) cyc(GO, GM, GO, "guard-valued pixels R8");
    pixels(3, 7, "guard-valued R8");
    idle(1, "guard-valued end R9");

    // R4: data-island preamble
    for (int n = 7; n <= 9; n++) begin
      idle(1, "island R4");
      for (int i = 0; i < n; i++) cyc(C11, C01, C01, "island R4");
      guard_pair("island R4");
      pixels(4, n, "island R4");
    end

    // R3: broken preamble
    idle(1, "broken R3");
    preamble(4, "broken R3");
    cyc(C00, C00, C00, "broken R3");
    preamble(4, "broken R3");
    guard_pair("broken R3");
    pixels(4, 3, "broken R3");

    // R6: corrupted guard word on each channel
    for (int ch = 0; ch < 3; ch++) begin
      idle(1, "bad guard R6");
      preamble(PRE, "bad guard R6");
      cyc(GO, GM, GO, "bad guard R6");
      cyc(ch == 0 ? 10'h2CD : GO, ch == 1 ? 10'h132 : GM, ch == 2 ? 10'h0CC : GO,
          "bad guard R6");
      pixels(3, ch, "bad guard R8");
    end

    // R7: control inside guard band
    idle(1, "abort R7");
    preamble(PRE, "abort R7");
    cyc(GO, GM, GO, "abort R7");
    cyc(GO, C01, GO, "abort R7");
    pixels(3, 9, "abort R7");

    // R9: control on a single channel ends pixels; that clock starts a new run
    for (int ch = 0; ch < 3; ch++) begin
      idle(1, "end R9");
      preamble(PRE, "end R9");
      guard_pair("end R9");
      pixels(3, ch + 20, "end R9");
      cyc(ch == 0 ? C11 : 10'h1F0, ch == 1 ? C01 : 10'h1F0, ch == 2 ? C00 : 10'h1F0,
          "single channel end R9");
      pixels(2, 4, "after end R9");
    end
    idle(1, "rerun R9");
    preamble(PRE, "rerun R9");
    guard_pair("rerun R9");
    pixels(2, 1, "rerun R9");
    preamble(PRE, "back-to-back R9");
    guard_pair("back-to-back R5");
    pixels(2, 2, "back-to-back R8");
    idle(2, "tail R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule